// File: doc/BRIEF.md
# Synchronous slave serial transceiver with wake

This block is a half-duplex serial port that only ever acts as a slave. An external master supplies the serial clock and the port shifts data in or out on that clock alone. Reception and transmission therefore keep running while the host clock is stopped. One word arrives on the data input and is sampled on falling serial clock edges. The completed word moves into a receive holding register. A transmit holding register feeds a separate shift register, so the host can queue the next byte while the current one is still going out.

Two flags report the state of the holding registers: receive data pending, and transmit holding register free. Each flag has its own enable, and a group enable gates both, to form a wake request. The wake logic is combinational across the clock domains, so it can assert while the host clock is halted. The host sees synchronised copies of the flags, a receive overrun flag, and single-cycle write and read strobes.

The shift registers live in the serial clock domain and the holding-register control lives in the host domain. They exchange toggle handshakes only.

Top module: `ssx_slave_port`

## Requirements
- R1: After reset, rx_full_o=0, tx_empty_o=1, overrun_o=0 and sd_oe_o=0. With all enables low, wake_o=0.
- R2: With rx_en_i=1 and tx_en_i=0, the port samples sd_i on eight falling edges of sclk_i. The first bit becomes bit 0 of the word. Within 3 clk_i cycles after the eighth falling edge, the word is on rx_data_o and rx_full_o=1.
- R3: A rx_rd_i pulse while rx_full_o=1 clears rx_full_o at the next clk_i edge. A pulse while rx_full_o=0 has no effect.
- R4: If a word completes while the previous word is unread, the new word is discarded, rx_data_o keeps the old word, and overrun_o=1. overrun_o stays set across reads and clears only when the receiver is disabled (rx_en_i=0 or tx_en_i=1). Reception continues after the old word is read.
- R5: The receiver ignores sclk_i while rx_en_i=0 or tx_en_i=1. Disabling the receiver discards a partly received word, so the next word starts at bit 0.
- R6: A tx_wr_i pulse while tx_empty_o=1 captures tx_data_i and clears tx_empty_o at the next clk_i edge. A tx_wr_i pulse while tx_empty_o=0 is dropped.
- R7: With tx_en_i=1, a pending byte is driven on sd_o LSB first, each bit changing on a rising edge of sclk_i. Bit 0 comes from the holding register at the first rising edge. After that word's first falling edge, the holding register is free again and tx_empty_o returns to 1.
- R8: A byte written while a word is shifting moves into the shift register at that word's eighth falling edge and sets tx_empty_o. It follows on sd_o with no gap.
- R9: sd_oe_o is high from the first rising edge of a transmitted word until its last falling edge, and only while tx_en_i=1. It is low when nothing is pending.
- R10: wake_o = grp_ie_i & ((rx_ie_i & word pending) | (tx_ie_i & transmit holding free)). It is formed without clk_i, so a word received with the host clock halted raises wake_o before rx_full_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receiver enable |
| tx_en_i | input | 1 | Transmitter enable; has priority over reception |
| rx_ie_i | input | 1 | Wake enable for received data |
| tx_ie_i | input | 1 | Wake enable for free transmit holding register |
| grp_ie_i | input | 1 | Group wake enable |
| tx_wr_i | input | 1 | Write strobe for the transmit holding register |
| tx_data_i | input | DATA_W | Byte to transmit |
| rx_rd_i | input | 1 | Read strobe for the receive holding register |
| rx_data_o | output | DATA_W | Received word |
| rx_full_o | output | 1 | Received word waiting (host domain) |
| tx_empty_o | output | 1 | Transmit holding register free (host domain) |
| overrun_o | output | 1 | Received word lost |
| wake_o | output | 1 | Wake/interrupt request, valid without clk_i |
| sclk_i | input | 1 | Serial clock from the master |
| sd_i | input | 1 | Serial data in from the data pad |
| sd_o | output | 1 | Serial data out to the data pad |
| sd_oe_o | output | 1 | Data pad output enable |

## Verification
The bench uses the defaults, DATA_W=8 and SYNC_STAGES=2. With 8-bit words, random bytes and the single-bit extremes 0x01 and 0x80 cover every bit position and both ends of the LSB-first order. With two synchroniser stages the host flags settle within three host cycles, which is less than a serial half period. Every flag can therefore be checked between serial edges, including the back-to-back hand-over at the eighth falling edge. The short synchroniser also makes the halted-clock case observable: wake_o rises while rx_full_o still holds its old value.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  parameter int unsigned DefDataW      = 8;
  parameter int unsigned DefSyncStages = 2;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= g_stage[s-1].q;
    end
  end

  assign q_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/ssx_rx.sv
module ssx_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              sd_i,
  input  logic              ack_i,
  output logic              tog_o,
  output logic [DATA_W-1:0] hold_o,
  output logic              ovr_o
);
  localparam int unsigned   CW   = ssx_pkg::idx_w(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic              clr_n;
  logic [DATA_W-1:0] sh_q, hold_q, word;
  logic [CW-1:0]     cnt_q;
  logic              tog_q, ovr_q, done, full;

  assign clr_n = rst_ni & act_i;
  assign done  = (cnt_q == LAST);
  assign full  = tog_q ^ ack_i;
  assign word  = {sd_i, sh_q[DATA_W-1:1]};  // LSB first: bits enter at the top

  // bit position and overrun are dropped whenever the receiver is off
  always_ff @(negedge sclk_i or negedge clr_n)
    if (!clr_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      sh_q  <= word;
      cnt_q <= done ? '0 : cnt_q + 1'b1;
      if (done && full) ovr_q <= 1'b1;
    end

  always_ff @(negedge sclk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_q <= '0;
      tog_q  <= 1'b0;
    end else if (clr_n && done && !full) begin
      hold_q <= word;
      tog_q  <= ~tog_q;
    end

  assign tog_o  = tog_q;
  assign hold_o = hold_q;
  assign ovr_o  = ovr_q;

  a_r4_overrun_keeps_hold: assert property (@(negedge sclk_i) disable iff (!clr_n)
    (done && full) |=> $stable(hold_q));
endmodule

// File: rtl/ssx_tx.sv
module ssx_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] hold_i,
  output logic              take_o,
  output logic              sd_o,
  output logic              oe_o
);
  localparam int unsigned   CW   = ssx_pkg::idx_w(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic              clr_n, pending, load_first, load_next;
  logic [DATA_W-1:0] tsr_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q, start_q, sd_q, take_q;

  assign clr_n      = rst_ni & act_i;
  assign pending    = tog_i ^ take_q;
  assign load_first = !busy_q && start_q;
  assign load_next  = busy_q && (cnt_q == LAST) && pending;

  // rising edge: present the next bit; an idle shifter takes bit 0 straight from the holding register
  always_ff @(posedge sclk_i or negedge clr_n)
    if (!clr_n) begin
      start_q <= 1'b0;
      sd_q    <= 1'b0;
    end else begin
      start_q <= !busy_q && pending;
      sd_q    <= busy_q ? tsr_q[cnt_q] : hold_i[0];
    end

  // falling edge: master has sampled, advance or hand over
  always_ff @(negedge sclk_i or negedge clr_n)
    if (!clr_n) begin
      tsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_first) begin
      tsr_q  <= hold_i;
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        if (pending) tsr_q  <= hold_i;
        else         busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

  always_ff @(negedge sclk_i or negedge rst_ni)
    if (!rst_ni)                                   take_q <= 1'b0;
    else if (clr_n && (load_first || load_next))   take_q <= ~take_q;

  assign take_o = take_q;
  assign sd_o   = sd_q;
  assign oe_o   = busy_q | start_q;
endmodule

// File: rtl/ssx_host.sv
module ssx_host #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  input  logic              rx_tog_i,
  input  logic              take_i,
  input  logic              ovr_i,
  output logic              tx_tog_o,
  output logic [DATA_W-1:0] tx_hold_o,
  output logic              rx_ack_o,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              overrun_o
);
  logic [2:0]        sync_q;
  logic [DATA_W-1:0] hold_q;
  logic              tog_q, ack_q;

  ssx_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ovr_i, take_i, rx_tog_i}),
    .q_o   (sync_q)
  );

  assign rx_full_o  = sync_q[0] ^ ack_q;
  assign tx_empty_o = ~(tog_q ^ sync_q[1]);
  assign overrun_o  = sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      hold_q <= '0;
      tog_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (tx_wr_i && tx_empty_o) begin
        hold_q <= tx_data_i;
        tog_q  <= ~tog_q;
      end
      if (rx_rd_i && rx_full_o) ack_q <= ~ack_q;
    end

  assign tx_tog_o  = tog_q;
  assign tx_hold_o = hold_q;
  assign rx_ack_o  = ack_q;

  a_r3_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && rx_full_o) |=> !rx_full_o);
  a_r6_write_fills_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && tx_empty_o) |=> !tx_empty_o);
endmodule

// File: rtl/ssx_slave_port.sv
module ssx_slave_port #(
  parameter int unsigned DATA_W      = ssx_pkg::DefDataW,
  parameter int unsigned SYNC_STAGES = ssx_pkg::DefSyncStages
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic              rx_ie_i,
  input  logic              tx_ie_i,
  input  logic              grp_ie_i,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              overrun_o,
  output logic              wake_o,
  input  logic              sclk_i,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe_o
);
  logic              rx_tog, rx_ack, rx_ovr, tx_tog, tx_take;
  logic [DATA_W-1:0] tx_hold;

  ssx_host #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_host (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_wr_i   (tx_wr_i),
    .tx_data_i (tx_data_i),
    .rx_rd_i   (rx_rd_i),
    .rx_tog_i  (rx_tog),
    .take_i    (tx_take),
    .ovr_i     (rx_ovr),
    .tx_tog_o  (tx_tog),
    .tx_hold_o (tx_hold),
    .rx_ack_o  (rx_ack),
    .rx_full_o (rx_full_o),
    .tx_empty_o(tx_empty_o),
    .overrun_o (overrun_o)
  );

  ssx_rx #(.DATA_W(DATA_W)) i_rx (
    .sclk_i(sclk_i),
    .rst_ni(rst_ni),
    .act_i (rx_en_i & ~tx_en_i),
    .sd_i  (sd_i),
    .ack_i (rx_ack),
    .tog_o (rx_tog),
    .hold_o(rx_data_o),
    .ovr_o (rx_ovr)
  );

  ssx_tx #(.DATA_W(DATA_W)) i_tx (
    .sclk_i(sclk_i),
    .rst_ni(rst_ni),
    .act_i (tx_en_i),
    .tog_i (tx_tog),
    .hold_i(tx_hold),
    .take_o(tx_take),
    .sd_o  (sd_o),
    .oe_o  (sd_oe_o)
  );

  // raw toggle compares: usable with clk_i halted, one bit changes at a time
  assign wake_o = grp_ie_i & ((rx_ie_i & (rx_tog ^ rx_ack)) |
                              (tx_ie_i & ~(tx_tog ^ tx_take)));

  a_r9_drive_needs_tx_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> tx_en_i);
  a_r10_wake_needs_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grp_ie_i |-> !wake_o);
endmodule

// File: tb/test_ssx_slave_port.sv
module test_ssx_slave_port;
  logic clk = 1'b0, rst_ni = 1'b0, clk_run = 1'b1;
  logic rx_en = 0, tx_en = 0, rx_ie = 0, tx_ie = 0, grp_ie = 0;
  logic tx_wr = 0, rx_rd = 0, sclk = 0, sd_i = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic rx_full, tx_empty, overrun, wake, sd_o, sd_oe;
  int errors = 0, checks = 0;

  always begin
    #10;
    if (clk_run || clk) clk = ~clk;  // halts low
  end

  ssx_slave_port i_ssx_slave_port (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en), .tx_en_i(tx_en),
    .rx_ie_i(rx_ie), .tx_ie_i(tx_ie), .grp_ie_i(grp_ie),
    .tx_wr_i(tx_wr), .tx_data_i(tx_data), .rx_rd_i(rx_rd),
    .rx_data_o(rx_data), .rx_full_o(rx_full), .tx_empty_o(tx_empty),
    .overrun_o(overrun), .wake_o(wake),
    .sclk_i(sclk), .sd_i(sd_i), .sd_o(sd_o), .sd_oe_o(sd_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); tx_wr = 1; tx_data = b;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic rd();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic rx_bit(input logic b);
    sclk = 1; sd_i = b; #100;
    sclk = 0; #100;
  endtask

  task automatic rx_word(input logic [7:0] w);
    for (int i = 0; i < 8; i++) rx_bit(w[i]);
  endtask

  task automatic tx_bit(output logic b, output logic oe);
    sclk = 1; #60;
    b = sd_o; oe = sd_oe; #40;
    sclk = 0; #100;
  endtask

  task automatic tx_word(output logic [7:0] w, output logic oe_all);
    logic b, oe;
    oe_all = 1;
    for (int i = 0; i < 8; i++) begin
      tx_bit(b, oe); w[i] = b; oe_all &= oe;
    end
  endtask

  function automatic logic [7:0] pick(input int k);
    if (k == 0) return 8'h01;
    if (k == 1) return 8'h80;
    return 8'($urandom);
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] a, b, c, got;
    logic bit_v, oe_v, oe_all;
    void'($urandom(32'h5EED_0C17));
    #55 rst_ni = 1;
    cyc(2);
    // R1
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 overrun", overrun, 0);
    chk("R1 sd_oe", sd_oe, 0);
    chk("R1 wake", wake, 0);
    // R10 transmit side gating
    tx_ie = 1; cyc(1);
    chk("R10 wake without group", wake, 0);
    grp_ie = 1; cyc(1);
    chk("R10 wake on free tx hold", wake, 1);
    tx_ie = 0; grp_ie = 0;

    // R2 / R3 reception
    rx_en = 1; cyc(1);
    for (int k = 0; k < 8; k++) begin
      a = pick(k);
      rx_word(a); cyc(1);
      chk("R2 rx_full", rx_full, 1);
      chk("R2 rx_data", rx_data, a);
      rd();
      chk("R3 read clears", rx_full, 0);
    end
    rd();
    chk("R3 read when empty", rx_full, 0);
    a = 8'h5A; rx_word(a); cyc(1);
    chk("R3 after empty read full", rx_full, 1);
    chk("R3 after empty read data", rx_data, a);
    rd();

    // R10 with host clock halted
    rx_ie = 1; grp_ie = 1;
    @(negedge clk); clk_run = 0; #40;
    a = 8'($urandom); rx_word(a);
    chk("R10 wake while halted", wake, 1);
    chk("R10 host flag waits for clock", rx_full, 0);
    clk_run = 1; cyc(4);
    chk("R10 flag after restart", rx_full, 1);
    chk("R10 data after restart", rx_data, a);
    rd(); cyc(1);
    chk("R10 wake drops after read", wake, 0);
    grp_ie = 0;
    rx_word(8'h3C); cyc(1);
    chk("R10 group off", wake, 0);
    rd(); rx_ie = 0;

    // R4 overrun
    a = 8'($urandom); b = ~a;
    rx_word(a); rx_word(b); cyc(1);
    chk("R4 overrun set", overrun, 1);
    chk("R4 old word kept", rx_data, a);
    rd();
    chk("R4 overrun sticky", overrun, 1);
    c = 8'($urandom); rx_word(c); cyc(1);
    chk("R4 reception resumes", rx_data, c);
    rd();
    rx_en = 0; cyc(4);
    chk("R4 overrun cleared by disable", overrun, 0);

    // R5 receiver off / partial word / transmit priority
    rx_word(8'hA5); cyc(1);
    chk("R5 disabled ignores clocks", rx_full, 0);
    rx_en = 1; cyc(1);
    rx_bit(1); rx_bit(0); rx_bit(1);
    rx_en = 0; cyc(2); rx_en = 1; cyc(1);
    a = 8'($urandom); rx_word(a); cyc(1);
    chk("R5 realigned word", rx_data, a);
    rd();
    tx_en = 1; cyc(1);
    rx_word(8'hC3); cyc(1);
    chk("R5 tx priority", rx_full, 0);
    chk("R9 idle no drive", sd_oe, 0);
    rx_en = 0;

    // R6 / R7 / R8 / R9 transmission
    for (int k = 0; k < 5; k++) begin
      a = pick(k); b = 8'($urandom);
      tx_ie = 1; grp_ie = 1;
      wr(a);
      chk("R6 empty cleared", tx_empty, 0);
      chk("R10 wake follows tx hold", wake, 0);
      tx_ie = 0; grp_ie = 0;
      wr(~a);
      tx_bit(bit_v, oe_v);
      got[0] = bit_v; oe_all = oe_v;
      cyc(1);
      chk("R7 hold free after first bit", tx_empty, 1);
      wr(b);
      chk("R8 second byte queued", tx_empty, 0);
      for (int i = 1; i < 8; i++) begin
        tx_bit(bit_v, oe_v); got[i] = bit_v; oe_all &= oe_v;
      end
      cyc(1);
      chk("R8 handover sets empty", tx_empty, 1);
      chk("R7 word out (R6 drop)", got, a);
      chk("R9 drive during word", oe_all, 1);
      tx_word(got, oe_all);
      chk("R8 back-to-back word", got, b);
      chk("R9 drive second word", oe_all, 1);
      chk("R9 released after word", sd_oe, 0);
    end
    tx_bit(bit_v, oe_v);
    chk("R9 no drive when nothing pending", oe_v, 0);
    tx_en = 0;

    summary();
    $finish;
  end
endmodule